// File: doc/BRIEF.md
# Framed Four-Bit Pattern Detector

This block watches a serial bit stream, one qualified bit per clock, and cuts it into consecutive four-bit frames that never overlap. When the frame just completed reads 0101 or 1001, counted from its first bit to its last, the block raises its match output. The match is driven during the same cycle as the frame's fourth bit. After every fourth accepted bit the machine goes back to its start state, whether or not the frame matched, and the next frame begins with the next accepted bit.

The controller is a Mealy machine with seven states. These are the minimum needed, because prefixes that lead to the same future behaviour share one state. The prefixes 01 and 10 share a state, and every prefix that can no longer match goes down a shared dead path. Cycles in which the valid qualifier is low do not count toward a frame. A synchronous active-high reset restarts framing from the start state.

Top module: `fdet_frame_detector`

## Requirements
- R1: During reset and in the first cycle after it, the match output is 0. The first accepted bit after reset is bit one of a new frame, so 0101 fed right after reset produces a match on its fourth bit.
- R2: A frame whose accepted bits, first to last, are 0,1,0,1 drives match to 1 during the cycle in which its fourth bit is presented with valid high.
- R3: A frame whose accepted bits, first to last, are 1,0,0,1 drives match to 1 during its fourth bit.
- R4: All 14 other four-bit frames give match 0 on every one of their bits.
- R5: Match is never 1 on the first, second or third accepted bit of a frame.
- R6: Frames are back to back and never overlap. The machine returns to its start state after every fourth accepted bit, so the stream 0,1,0,1,0,1,0,1 gives exactly two matches, on bits 4 and 8.
- R7: A cycle with valid low leaves the machine's state unchanged and holds match at 0, whatever the value on the data bit.
- R8: Match depends on the data bit presented in the current cycle. With the prefix 0,1,0 held, a fourth bit of 0 gives match 0 and a fourth bit of 1 gives match 1, both within the same cycle.
- R9: Reset asserted in the middle of a frame discards the partial frame. Framing restarts at the first accepted bit after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | High when bit_in carries an accepted bit this cycle |
| match_o | output | 1 | High for the fourth bit of a 0101 or 1001 frame |

## Verification
The hardest case to reach is a stall in the pending-match state: valid drops after three good bits while the data line already shows a 1. A correct design must neither assert match nor lose the frame in that cycle. The stimulus builds each matching prefix and then inserts idle cycles with bit_in forced high before each frame position, including the fourth. It also walks all sixteen frames back to back, so that every dead path and every merged prefix is entered from the start state. Finally, it overrides the fourth bit within a single cycle to show that the output follows the current input.

// File: rtl/fdet_pkg.sv
package fdet_pkg;

    localparam int unsigned FRAME_LEN = 4;
    localparam int unsigned POS_W     = $clog2(FRAME_LEN);
    localparam int unsigned STATE_W   = 3;

    // Seven states of the reduced frame machine
    typedef enum logic [STATE_W-1:0] {
        ST_START = 3'd0,  // no bit of the frame taken yet
        ST_GOT0  = 3'd1,  // first bit was 0
        ST_GOT1  = 3'd2,  // first bit was 1
        ST_MID   = 3'd3,  // prefix 01 or 10
        ST_LOST2 = 3'd4,  // two bits taken, no match possible
        ST_PEND  = 3'd5,  // prefix 010 or 100, match if next bit is 1
        ST_LOST3 = 3'd6   // three bits taken, no match possible
    } fdet_state_e;

    typedef struct packed {
        logic data;
        logic vld;
    } fdet_in_t;

    typedef struct packed {
        fdet_state_e nxt;
        logic        hit;
    } fdet_step_t;

    function automatic fdet_state_e fdet_advance(fdet_state_e cur, logic b);
        fdet_state_e r;
        case (cur)
            ST_START: r = b ? ST_GOT1  : ST_GOT0;
            ST_GOT0:  r = b ? ST_MID   : ST_LOST2;
            ST_GOT1:  r = b ? ST_LOST2 : ST_MID;
            ST_MID:   r = b ? ST_LOST3 : ST_PEND;
            ST_LOST2: r = ST_LOST3;
            ST_LOST3: r = ST_START;
            ST_PEND:  r = ST_START;
            default:  r = ST_START;
        endcase
        return r;
    endfunction

    function automatic logic fdet_hit(fdet_state_e cur, logic b);
        return (cur == ST_PEND) && b;
    endfunction

endpackage

// File: rtl/fdet_next_state.sv
module fdet_next_state
    import fdet_pkg::*;
(
    input  fdet_state_e cur_state,
    input  fdet_in_t    in_bit,
    output fdet_state_e nxt_state
);
    always_comb begin
        if (in_bit.vld) begin
            nxt_state = fdet_advance(cur_state, in_bit.data);
        end else begin
            nxt_state = cur_state;
        end
    end
endmodule

// File: rtl/fdet_match_logic.sv
module fdet_match_logic
    import fdet_pkg::*;
(
    input  fdet_state_e cur_state,
    input  fdet_in_t    in_bit,
    output logic        hit
);
    always_comb begin
        hit = in_bit.vld && fdet_hit(cur_state, in_bit.data);
    end
endmodule

// File: rtl/fdet_state_reg.sv
module fdet_state_reg
    import fdet_pkg::*;
#(
    parameter fdet_state_e RESET_STATE = ST_START
) (
    input  logic        clk,
    input  logic        rst,
    input  fdet_state_e d,
    output fdet_state_e q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RESET_STATE;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/fdet_frame_detector.sv
module fdet_frame_detector
    import fdet_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    input  logic bit_vld,
    output logic match_o
);
    fdet_in_t    in_s;
    fdet_state_e state_q;
    fdet_state_e state_d;
    fdet_step_t  step;
    logic        hit_raw;

    always_comb begin
        in_s.data = bit_in;
        in_s.vld  = bit_vld;
    end

    fdet_next_state u_next (
        .cur_state (state_q),
        .in_bit    (in_s),
        .nxt_state (state_d)
    );

    fdet_match_logic u_match (
        .cur_state (state_q),
        .in_bit    (in_s),
        .hit       (hit_raw)
    );

    fdet_state_reg #(.RESET_STATE(ST_START)) u_reg (
        .clk (clk),
        .rst (rst),
        .d   (step.nxt),
        .q   (state_q)
    );

    always_comb begin
        step.nxt = state_d;
        step.hit = hit_raw && !rst;
    end

    assign match_o = step.hit;
endmodule

// File: rtl/fdet_checker.sv
module fdet_checker
    import fdet_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        bit_in,
    input logic        bit_vld,
    input logic        match_o,
    input fdet_state_e state_q
);
    logic [POS_W-1:0]     pos;
    logic [FRAME_LEN-2:0] hist;
    logic                 frame_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos  <= '0;
            hist <= '0;
        end else if (bit_vld) begin
            pos  <= pos + 1'b1;
            hist <= {hist[FRAME_LEN-3:0], bit_in};
        end
    end

    assign frame_ok = ({hist, bit_in} == 4'b0101) || ({hist, bit_in} == 4'b1001);

    // R7: no match without a valid bit
    assert_match_needs_vld_R7: assert property (@(posedge clk) disable iff (rst)
        match_o |-> bit_vld);

    // R7: idle cycle holds state
    assert_idle_holds_R7: assert property (@(posedge clk) disable iff (rst)
        !bit_vld |=> $stable(state_q));

    // R5: match only on the last frame position
    assert_last_bit_only_R5: assert property (@(posedge clk) disable iff (rst)
        match_o |-> (pos == POS_W'(FRAME_LEN-1)));

    // R2 and R3: accepted patterns produce match on the fourth bit
    assert_pattern_hit_R2: assert property (@(posedge clk) disable iff (rst)
        (bit_vld && pos == POS_W'(FRAME_LEN-1) && frame_ok) |-> match_o);

    // R4: other frames give no match
    assert_other_miss_R4: assert property (@(posedge clk) disable iff (rst)
        match_o |-> frame_ok);

    // R6: back to start after every fourth accepted bit
    assert_frame_return_R6: assert property (@(posedge clk) disable iff (rst)
        (bit_vld && pos == POS_W'(FRAME_LEN-1)) |=> (state_q == ST_START));
endmodule

bind fdet_frame_detector fdet_checker u_fdet_chk (
    .clk     (clk),
    .rst     (rst),
    .bit_in  (bit_in),
    .bit_vld (bit_vld),
    .match_o (match_o),
    .state_q (state_q)
);

// File: tb/fdet_frame_detector_tb_top.sv
`timescale 1ns/1ps
module fdet_frame_detector_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_in = 1'b0;
    logic bit_vld = 1'b0;
    logic match_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // reference model state
    int       ref_pos = 0;
    logic [2:0] ref_hist = 3'b000;

    always #2.5 clk = ~clk;

    fdet_frame_detector dut_i (
        .clk     (clk),
        .rst     (rst),
        .bit_in  (bit_in),
        .bit_vld (bit_vld),
        .match_o (match_o)
    );

    task automatic check(input logic act, input logic exp, input string req);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: match_o=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset(input string req);
        @(negedge clk);
        rst = 1'b1; bit_vld = 1'b0; bit_in = 1'b0;
        #1 check(match_o, 1'b0, req);
        @(negedge clk);
        rst = 1'b0;
        #1 check(match_o, 1'b0, req);
        ref_pos = 0; ref_hist = 3'b000;
    endtask

    // present one accepted bit, check match against the frame model
    task automatic send(input logic b, input string req);
        logic exp;
        @(negedge clk);
        bit_in = b; bit_vld = 1'b1;
        exp = (ref_pos == 3) && (({ref_hist, b} == 4'b0101) || ({ref_hist, b} == 4'b1001));
        #1 check(match_o, exp, req);
        ref_hist = {ref_hist[1:0], b};
        ref_pos  = (ref_pos + 1) % 4;
    endtask

    task automatic idle(input logic b, input string req);
        @(negedge clk);
        bit_in = b; bit_vld = 1'b0;
        #1 check(match_o, 1'b0, req);
    endtask

    task automatic send_frame(input logic [3:0] f, input string req);
        for (int i = 3; i >= 0; i--) send(f[i], req);
    endtask

    task automatic t_reset;
        do_reset("R1");
        send_frame(4'b0101, "R1");
    endtask

    task automatic t_all_frames;
        do_reset("R4");
        for (int f = 0; f < 16; f++) begin
            if (f == 5)      send_frame(4'(f), "R2");
            else if (f == 9) send_frame(4'(f), "R3");
            else             send_frame(4'(f), "R4_R5");
        end
    endtask

    task automatic t_back_to_back;
        int hits = 0;
        do_reset("R6");
        for (int k = 0; k < 8; k++) begin
            send(k[0], "R6");
            if (match_o) hits++;
        end
        n_tests++;
        if (hits != 2) begin
            n_fail++;
            $display("FAIL R6: hits=%0d expected 2", hits);
        end
        send_frame(4'b1010, "R6");
        send_frame(4'b1001, "R6");
    endtask

    task automatic t_stall;
        do_reset("R7");
        idle(1'b1, "R7");
        send(1'b0, "R7");
        idle(1'b1, "R7");
        send(1'b1, "R7");
        idle(1'b1, "R7");
        send(1'b0, "R7");
        idle(1'b1, "R7");
        idle(1'b1, "R7");
        send(1'b1, "R7");
        idle(1'b1, "R7");
        send_frame(4'b1001, "R7");
    endtask

    task automatic t_mealy;
        do_reset("R8");
        send(1'b0, "R8");
        send(1'b1, "R8");
        send(1'b0, "R8");
        @(negedge clk);
        bit_in = 1'b0; bit_vld = 1'b1;
        #1 check(match_o, 1'b0, "R8");
        bit_in = 1'b1;
        #1 check(match_o, 1'b1, "R8");
        ref_hist = 3'b000; ref_pos = 0;
        send_frame(4'b0101, "R8");
    endtask

    task automatic t_mid_reset;
        do_reset("R9");
        send(1'b0, "R9");
        send(1'b1, "R9");
        do_reset("R9");
        send_frame(4'b0101, "R9");
        send(1'b1, "R9");
        send(1'b0, "R9");
        send(1'b0, "R9");
        do_reset("R9");
        send_frame(4'b1001, "R9");
    endtask

    initial begin
        t_reset();
        t_all_frames();
        t_back_to_back();
        t_stall();
        t_mealy();
        t_mid_reset();
        @(negedge clk);
        bit_vld = 1'b0;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule